// File: doc/BRIEF.md
# Inter-processor interrupt message receiver

This block sits on a processor's inbound write path and watches every memory-mapped write for an interrupt message addressed to its own processor. A write is a 64-bit physical address plus a 64-bit data word, qualified by a single valid strobe. The address selects the target. The upper bits must match a relocatable interrupt block base. Two 8-bit fields must match this processor's configured identifiers. The three lowest bits must be zero.

The data word carries an 8-bit vector and a 3-bit delivery mode. The mode picks one of five pend actions, and each action has its own vector legality rule. The results are held in local pending state until an acknowledge interface clears them. That state is a 256-bit external interrupt pending vector, a 4-bit management interrupt pending set, and three single flags for NMI, INIT and the legacy external controller. Messages that carry a reserved mode or an illegal vector raise a one-cycle drop pulse. Messages that set the unused address bit are dropped and also raise a one-cycle error pulse.

Every effect of a write is registered. The pend bits, the drop pulse and the error pulse all change on the clock edge that samples the write, so they are visible in the following cycle.

Top module: `ipi_receiver`

## Requirements
- R1: After reset all pend outputs are 0, `drop_o` and `err_o` are 0, and the interrupt block base is 0xFEE, so that the block sits at physical address 0xFEE00000.
- R2: A write is accepted only when all of the following hold: `wr_valid` is 1, `wr_addr[63:20]` equals the current base, `wr_addr[19:12]` equals `cfg_id`, `wr_addr[11:4]` equals `cfg_eid`, and `wr_addr[2:0]` is 0. Any other write changes no pend bit and raises no pulse.
- R3: When `base_load` is 1, `base_value` replaces the base on that edge. Later matching uses the new base and no longer uses the old one.
- R4: Mode `wr_data[10:8]`=000 with vector v=`wr_data[7:0]` sets `ext_pend[v]` when v is 0, 2, or 16 to 255. Any other v sets nothing and pulses `drop_o`.
- R5: Mode 010 with v below 4 sets `mgmt_pend[v]`. With v of 4 or more it sets nothing and pulses `drop_o`.
- R6: Mode 100 sets `nmi_pend` for every vector value.
- R7: Mode 101 sets `init_pend` for every vector value.
- R8: Mode 111 sets `lgcy_pend` (legacy delivery at external vector 0) for every vector value.
- R9: Modes 001, 011 and 110 set nothing and pulse `drop_o`.
- R10: An accepted address with bit 3 equal to 1 sets nothing and pulses both `drop_o` and `err_o` for one cycle.
- R11: Every pend bit holds until its clear input is 1 on an edge. After such an edge the bit reads 0.
- R12: When a set and a clear for the same bit arrive on the same edge, the bit ends up 1.
- R13: `wr_data[63:11]` has no effect on any output.
- R14: The effects of a write are visible in the cycle after the edge that samples it, and `drop_o`/`err_o` last exactly one cycle per offending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 64 | Write physical address |
| wr_data | input | 64 | Write data word |
| cfg_id | input | 8 | This processor's id |
| cfg_eid | input | 8 | This processor's eid |
| base_load | input | 1 | Load a new interrupt block base |
| base_value | input | 44 | New base, address bits 63:20 |
| ext_clr | input | 256 | Per-vector external pend clear |
| mgmt_clr | input | 4 | Management pend clear |
| nmi_clr | input | 1 | NMI pend clear |
| init_clr | input | 1 | INIT pend clear |
| lgcy_clr | input | 1 | Legacy pend clear |
| ext_pend | output | 256 | External interrupt pending vector |
| mgmt_pend | output | 4 | Management interrupt pending set |
| nmi_pend | output | 1 | NMI pending |
| init_pend | output | 1 | INIT pending |
| lgcy_pend | output | 1 | Legacy controller interrupt pending |
| drop_o | output | 1 | One-cycle pulse for a dropped message |
| err_o | output | 1 | One-cycle pulse for an unused-bit message |

## Verification
The bench builds the block with its default parameters: a 64-bit address, 8-bit identifiers, a 256-entry external vector and 4 management slots. Because the vector and mode fields are small, the bench can sweep every combination of the eight modes and 256 vectors. That full product reaches every legality boundary (1, 2, 3, 15, 16 and 3, 4) without picking samples by hand. Directed writes then cover identifier, base and low-bit mismatches, the unused bit, base relocation, and set/clear collisions.

// File: rtl/ipi_rx_pkg.sv
package ipi_rx_pkg;
  localparam int VEC_W  = 8;
  localparam int EXT_N  = 1 << VEC_W;
  localparam int MGMT_N = 4;
  localparam int MGMT_W = $clog2(MGMT_N);
  localparam int MODE_W = 3;

  localparam logic [VEC_W-1:0] V_NMI_SLOT  = VEC_W'(2);
  localparam logic [VEC_W-1:0] V_FIRST_OPEN = VEC_W'(16);
  localparam logic [VEC_W-1:0] V_MGMT_LIM  = VEC_W'(MGMT_N);

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_RSV_A  = 3'b001,
    DM_MGMT   = 3'b010,
    DM_RSV_B  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_RSV_C  = 3'b110,
    DM_LEGACY = 3'b111
  } dmode_e;

  typedef struct packed {
    logic              ext;
    logic [VEC_W-1:0]  vec;
    logic [MGMT_N-1:0] mgmt;
    logic              nmi;
    logic              init;
    logic              lgcy;
    logic              drop;
    logic              err;
  } act_t;
endpackage

// File: rtl/ipi_rx_filter.sv
module ipi_rx_filter #(
  parameter int ADDR_W = 64,
  parameter int ID_W   = 8
) (
  input  logic                        valid,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ADDR_W-2*ID_W-5:0]    base,
  input  logic [ID_W-1:0]             my_id,
  input  logic [ID_W-1:0]             my_eid,
  output logic                        hit,
  output logic                        unused_set
);
  localparam int EID_LSB  = 4;
  localparam int ID_LSB   = EID_LSB + ID_W;
  localparam int BASE_LSB = ID_LSB + ID_W;

  always_comb begin
    hit = valid
       && (addr[ADDR_W-1:BASE_LSB] == base)
       && (addr[BASE_LSB-1:ID_LSB] == my_id)
       && (addr[ID_LSB-1:EID_LSB] == my_eid)
       && (addr[2:0] == 3'b000);
    unused_set = addr[3];
  end
endmodule

// File: rtl/ipi_rx_decode.sv
module ipi_rx_decode
  import ipi_rx_pkg::*;
(
  input  logic              hit,
  input  logic              unused_set,
  input  logic [MODE_W-1:0] mode,
  input  logic [VEC_W-1:0]  vec,
  output act_t              act
);
  logic vec_fixed_ok;
  assign vec_fixed_ok = (vec == '0) || (vec == V_NMI_SLOT) || (vec >= V_FIRST_OPEN);

  always_comb begin
    act     = '0;
    act.vec = vec;
    if (hit) begin
      if (unused_set) begin
        act.drop = 1'b1;
        act.err  = 1'b1;
      end else begin
        case (dmode_e'(mode))
          DM_FIXED: begin
            if (vec_fixed_ok) act.ext = 1'b1;
            else              act.drop = 1'b1;
          end
          DM_MGMT: begin
            if (vec < V_MGMT_LIM) act.mgmt[vec[MGMT_W-1:0]] = 1'b1;
            else                  act.drop = 1'b1;
          end
          DM_NMI:    act.nmi  = 1'b1;
          DM_INIT:   act.init = 1'b1;
          DM_LEGACY: act.lgcy = 1'b1;
          default:   act.drop = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_rx_pend.sv
module ipi_rx_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= (q & ~clr) | set;
      armed <= 1'b1;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((q & $past(set)) == $past(set))); // R12
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((q & $past(clr & ~set)) == '0)); // R11
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    armed |-> (($past(q) & ~$past(clr) & ~q) == '0)); // R11
endmodule

// File: rtl/ipi_receiver.sv
module ipi_receiver
  import ipi_rx_pkg::*;
#(
  parameter int          ADDR_W        = 64,
  parameter int          DATA_W        = 64,
  parameter int          ID_W          = 8,
  parameter logic [63:0] BASE_ADDR_RST = 64'h0000_0000_FEE0_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_valid,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ID_W-1:0]           cfg_id,
  input  logic [ID_W-1:0]           cfg_eid,
  input  logic                      base_load,
  input  logic [ADDR_W-2*ID_W-5:0]  base_value,
  input  logic [EXT_N-1:0]          ext_clr,
  input  logic [MGMT_N-1:0]         mgmt_clr,
  input  logic                      nmi_clr,
  input  logic                      init_clr,
  input  logic                      lgcy_clr,
  output logic [EXT_N-1:0]          ext_pend,
  output logic [MGMT_N-1:0]         mgmt_pend,
  output logic                      nmi_pend,
  output logic                      init_pend,
  output logic                      lgcy_pend,
  output logic                      drop_o,
  output logic                      err_o
);
  localparam int BASE_LSB = 4 + 2 * ID_W;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int MODE_LSB = VEC_W;

  logic [BASE_W-1:0] base_q;
  logic              hit, unused_set, armed;
  act_t              act;
  logic [EXT_N-1:0]  ext_set;
  logic [2:0]        flag_q;
  logic              data_hi_unused;

  assign data_hi_unused = ^wr_data[DATA_W-1:MODE_LSB+MODE_W];

  always_ff @(posedge clk) begin
    if (rst)            base_q <= BASE_ADDR_RST[ADDR_W-1:BASE_LSB];
    else if (base_load) base_q <= base_value;
  end

  ipi_rx_filter #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_filter (
    .valid(wr_valid), .addr(wr_addr), .base(base_q),
    .my_id(cfg_id), .my_eid(cfg_eid),
    .hit(hit), .unused_set(unused_set)
  );

  ipi_rx_decode u_decode (
    .hit(hit), .unused_set(unused_set),
    .mode(wr_data[MODE_LSB+MODE_W-1:MODE_LSB]),
    .vec(wr_data[VEC_W-1:0]),
    .act(act)
  );

  always_comb begin
    for (int i = 0; i < EXT_N; i++)
      ext_set[i] = act.ext && (act.vec == VEC_W'(i));
  end

  ipi_rx_pend #(.N(EXT_N)) u_ext_bank (
    .clk(clk), .rst(rst), .set(ext_set), .clr(ext_clr), .q(ext_pend)
  );

  ipi_rx_pend #(.N(MGMT_N)) u_mgmt_bank (
    .clk(clk), .rst(rst), .set(act.mgmt), .clr(mgmt_clr), .q(mgmt_pend)
  );

  ipi_rx_pend #(.N(3)) u_flag_bank (
    .clk(clk), .rst(rst),
    .set({act.lgcy, act.init, act.nmi}),
    .clr({lgcy_clr, init_clr, nmi_clr}),
    .q(flag_q)
  );
  assign {lgcy_pend, init_pend, nmi_pend} = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_o <= 1'b0;
      err_o  <= 1'b0;
      armed  <= 1'b0;
    end else begin
      drop_o <= act.drop;
      err_o  <= act.err;
      armed  <= 1'b1;
    end
  end

  AST_ERR_WITH_DROP: assert property (@(posedge clk) disable iff (rst)
    err_o |-> drop_o); // R10
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    armed && drop_o |-> $past(wr_valid)); // R14
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(base_load) |-> $stable(base_q)); // R3
  AST_NO_SPURIOUS_EXT: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(wr_valid) |-> ((ext_pend & ~$past(ext_pend)) == '0)); // R2
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act.ext, |act.mgmt, act.nmi, act.init, act.lgcy, act.drop})); // R9
endmodule

// File: tb/ipi_receiver_bench.sv
`timescale 1ns/1ps
module ipi_receiver_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_valid;
  logic [63:0]  wr_addr, wr_data;
  logic [7:0]   cfg_id, cfg_eid;
  logic         base_load;
  logic [43:0]  base_value;
  logic [255:0] ext_clr;
  logic [3:0]   mgmt_clr;
  logic         nmi_clr, init_clr, lgcy_clr;
  logic [255:0] ext_pend;
  logic [3:0]   mgmt_pend;
  logic         nmi_pend, init_pend, lgcy_pend, drop_o, err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ipi_receiver u_ipi_receiver (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_id(cfg_id), .cfg_eid(cfg_eid), .base_load(base_load), .base_value(base_value),
    .ext_clr(ext_clr), .mgmt_clr(mgmt_clr), .nmi_clr(nmi_clr), .init_clr(init_clr),
    .lgcy_clr(lgcy_clr), .ext_pend(ext_pend), .mgmt_pend(mgmt_pend), .nmi_pend(nmi_pend),
    .init_pend(init_pend), .lgcy_pend(lgcy_pend), .drop_o(drop_o), .err_o(err_o)
  );

  function automatic logic [63:0] mk_addr(logic [43:0] b, logic [7:0] id, logic [7:0] eid,
                                          logic u, logic [2:0] lo);
    return {b, id, eid, u, lo};
  endfunction

  function automatic logic [265:0] snap();
    return {ext_pend, mgmt_pend, nmi_pend, init_pend, lgcy_pend, drop_o, err_o};
  endfunction

  task automatic check(string tag, logic [265:0] act, logic [265:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // drive at negedge, sampled on next posedge, checked at following negedge
  task automatic send(logic [63:0] a, logic [63:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clear_all();
    ext_clr = '1; mgmt_clr = '1; nmi_clr = 1; init_clr = 1; lgcy_clr = 1;
    @(negedge clk);
    ext_clr = '0; mgmt_clr = '0; nmi_clr = 0; init_clr = 0; lgcy_clr = 0;
  endtask

  function automatic logic [265:0] expect_of(int m, int v);
    logic [255:0] e = '0;
    logic [3:0]   g = '0;
    logic n = 0, it = 0, l = 0, dr = 0;
    case (m)
      0: if (v == 0 || v == 2 || v >= 16) e[v] = 1'b1; else dr = 1;
      2: if (v < 4) g[v] = 1'b1; else dr = 1;
      4: n = 1;
      5: it = 1;
      7: l = 1;
      default: dr = 1;
    endcase
    return {e, g, n, it, l, dr, 1'b0};
  endfunction

  logic [43:0] home;
  logic [63:0] me;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1; wr_valid = 0; wr_addr = '0; wr_data = '0;
    cfg_id = 8'h5A; cfg_eid = 8'hC3; base_load = 0; base_value = '0;
    ext_clr = '0; mgmt_clr = '0; nmi_clr = 0; init_clr = 0; lgcy_clr = 0;
    home = 44'h0000_0000_FEE;
    me = mk_addr(home, 8'h5A, 8'hC3, 1'b0, 3'b000);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset state", snap(), '0);

    // R1: default base reaches the block
    send(me, 64'h400);
    check("R1 default base NMI", snap(), expect_of(4, 0));
    clear_all();

    // R4 R5 R6 R7 R8 R9 R13 R14: full mode x vector sweep with junk upper data
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 256; v++) begin
        send(me, {53'(v * 40503 + m * 977 + 1), 3'(m), 8'(v)});
        check($sformatf("R4-9 R13 R14 m=%0d v=%0d", m, v), snap(), expect_of(m, v));
        clear_all();
        check("R11 cleared / R14 pulse ends", snap(), '0);
      end
    end

    // R2: mismatches
    send(mk_addr(home, 8'h5B, 8'hC3, 0, 0), 64'h400);
    check("R2 wrong id", snap(), '0);
    send(mk_addr(home, 8'h5A, 8'hC2, 0, 0), 64'h400);
    check("R2 wrong eid", snap(), '0);
    send(mk_addr(44'h0000_0000_FEF, 8'h5A, 8'hC3, 0, 0), 64'h400);
    check("R2 wrong base", snap(), '0);
    for (int lo = 1; lo < 8; lo++) begin
      send(mk_addr(home, 8'h5A, 8'hC3, 0, 3'(lo)), 64'h400);
      check("R2 low bits", snap(), '0);
    end
    wr_addr = me; wr_data = 64'h400; wr_valid = 0;
    @(negedge clk);
    check("R2 no strobe", snap(), '0);

    // R10: unused bit
    send(mk_addr(home, 8'h5A, 8'hC3, 1, 0), 64'h0014);
    check("R10 unused bit", snap(), {256'b0, 4'b0, 3'b0, 2'b11});
    @(negedge clk);
    check("R10 pulse one cycle", snap(), '0);

    // R3: relocation
    base_value = 44'h123_4567_89A; base_load = 1;
    @(negedge clk);
    base_load = 0;
    send(me, 64'h500);
    check("R3 old base ignored", snap(), '0);
    send(mk_addr(44'h123_4567_89A, 8'h5A, 8'hC3, 0, 0), 64'h500);
    check("R3 new base", snap(), expect_of(5, 0));
    clear_all();
    home = 44'h123_4567_89A;
    me = mk_addr(home, 8'h5A, 8'hC3, 1'b0, 3'b000);

    // R11: hold and selective clear
    send(me, 64'h010);
    send(me, 64'h011);
    repeat (4) @(negedge clk);
    check("R11 hold", snap(), {256'h3 << 16, 4'b0, 5'b0});
    ext_clr[16] = 1;
    @(negedge clk);
    ext_clr = '0;
    check("R11 selective clear", snap(), {256'h1 << 17, 4'b0, 5'b0});
    clear_all();

    // R12: set and clear together
    ext_clr = '1; nmi_clr = 1; mgmt_clr = '1;
    send(me, 64'h014);
    check("R12 ext set wins", snap(), {256'h1 << 20, 4'b0, 5'b0});
    send(me, 64'h400);
    check("R12 nmi set wins", snap(), {256'h0, 4'b0, 5'b10000});
    send(me, 64'h203);
    check("R12 mgmt set wins", snap(), {256'h0, 4'b1000, 5'b0});
    ext_clr = '0; nmi_clr = 0; mgmt_clr = '0;
    clear_all();
    check("R12 final clear", snap(), '0);

    finish_run();
  end
endmodule